// File: doc/BRIEF.md
# Host-Slave Mailbox Channel

This block is one channel of a byte mailbox shared by an external host processor and a local slave processor. The host deposits a byte in the inbound register with an I/O write cycle and collects a byte from the outbound register with an I/O read cycle. The slave side reaches the same registers, plus a status byte and an interrupt enable, over a simple single-cycle local bus. The status byte carries the two handshake flags (inbound full, outbound full), a command/data marker taken from the host address on each write, and five general-purpose bits that slave firmware may use freely.

A host write lands in the inbound register whichever of the two host addresses it uses; the host select line (the address bit that distinguishes the two host locations) is recorded as the command/data marker. On host reads the same select line picks the outbound byte (select low) or the status byte (select high). The slave gets a level interrupt while inbound data waits and the interrupt is enabled.

Top module: `hs_mailbox`

## Requirements
- R1: After reset the status byte, both data registers and the interrupt enable are 0, and slv_irq is low.
- R2: A host write (host_cs and host_wr high at a clock edge) stores host_wdata in the inbound register and sets inbound-full, status bit 1, from the next cycle.
- R3: Each host write copies host_sel into status bit 3 (1 = command, 0 = data).
- R4: A slave read at slave address 0 returns the inbound byte and clears inbound-full after that edge.
- R5: A slave write at slave address 0 stores the outbound byte and sets outbound-full, status bit 0; a host read with host_sel low returns that byte and clears outbound-full; a host read with host_sel high returns the status byte and clears nothing.
- R6: A slave write at slave address 1 with data bit 0 low clears outbound-full; with data bit 0 high it leaves outbound-full unchanged; slave writes never change status bits 1 and 3.
- R7: Status bits 7 to 4 and bit 2 take the slave's data on a write at slave address 1, are read back at slave address 1 and by the host, and never change on host writes.
- R8: When a flag is set and cleared in the same cycle (host write with slave inbound read, or slave outbound write with host outbound read) it ends up set.
- R9: The interrupt enable is bit 0 at slave address 2 (read/write); slv_irq equals inbound-full AND the enable. Slave address 3 reads back the outbound byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs | input | 1 | Host channel select |
| host_wr | input | 1 | Host I/O write strobe |
| host_rd | input | 1 | Host I/O read strobe |
| host_sel | input | 1 | Host address select bit: command/data marker on writes, status/data choice on reads |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (outbound or status) |
| slv_we | input | 1 | Slave write strobe |
| slv_re | input | 1 | Slave read strobe |
| slv_addr | input | 2 | Slave register address |
| slv_wdata | input | 8 | Slave write byte |
| slv_rdata | output | 8 | Slave read byte |
| slv_irq | output | 1 | Level interrupt to the slave |

## Verification
Read data on both sides is combinational from the registers, so a read returns the state left by earlier edges in the same cycle it is issued, while flag and register updates caused by an access appear in the cycle after that edge. The bench drives each access on the falling edge, compares read data and slv_irq one nanosecond later against a model holding the state after the previous rising edge, and only then advances the model at the rising edge. Directed sequences probe each flag one cycle after the access that moves it, including the same-cycle set/clear collisions, and a seeded random run covers mixed traffic.

// File: rtl/hs_mbx_pkg.sv
package hs_mbx_pkg;
    localparam int BYTE_W    = 8;
    localparam int OBF_POS   = 0;
    localparam int IBF_POS   = 1;
    localparam int USR_POS   = 2;
    localparam int CD_POS    = 3;
    localparam logic [BYTE_W-1:0] USR_MASK = 8'hF4;

    typedef enum logic [1:0] {
        SLV_DATA   = 2'd0,
        SLV_STATUS = 2'd1,
        SLV_CTRL   = 2'd2,
        SLV_OUTRB  = 2'd3
    } slv_reg_e;

    typedef struct packed {
        logic              in_wr;
        logic              out_rd;
        logic              cd;
        logic [BYTE_W-1:0] wdata;
    } host_evt_t;

    typedef struct packed {
        logic              in_rd;
        logic              out_wr;
        logic              sts_wr;
        logic              ctl_wr;
        logic [BYTE_W-1:0] wdata;
    } slv_evt_t;

    typedef struct packed {
        logic [BYTE_W-1:0] in_byte;
        logic [BYTE_W-1:0] out_byte;
        logic [BYTE_W-1:0] usr;
        logic              cd;
        logic              ibf;
        logic              obf;
        logic              ie;
    } mbx_regs_t;
endpackage

// File: rtl/hs_mbx_host_port.sv
module hs_mbx_host_port
    import hs_mbx_pkg::*;
(
    input  logic              host_cs,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_sel,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic [BYTE_W-1:0] status,
    input  logic [BYTE_W-1:0] out_byte,
    output host_evt_t         evt,
    output logic [BYTE_W-1:0] host_rdata
);
    always_comb begin
        evt.in_wr  = host_cs & host_wr;
        evt.out_rd = host_cs & host_rd & ~host_sel;
        evt.cd     = host_sel;
        evt.wdata  = host_wdata;
        host_rdata = host_sel ? status : out_byte;
    end
endmodule

// File: rtl/hs_mbx_slave_port.sv
module hs_mbx_slave_port
    import hs_mbx_pkg::*;
(
    input  logic              slv_we,
    input  logic              slv_re,
    input  logic [1:0]        slv_addr,
    input  logic [BYTE_W-1:0] slv_wdata,
    input  mbx_regs_t         regs,
    input  logic [BYTE_W-1:0] status,
    output slv_evt_t          evt,
    output logic [BYTE_W-1:0] slv_rdata
);
    slv_reg_e sel;

    always_comb begin
        sel        = slv_reg_e'(slv_addr);
        evt.in_rd  = slv_re & (sel == SLV_DATA);
        evt.out_wr = slv_we & (sel == SLV_DATA);
        evt.sts_wr = slv_we & (sel == SLV_STATUS);
        evt.ctl_wr = slv_we & (sel == SLV_CTRL);
        evt.wdata  = slv_wdata;
        unique case (sel)
            SLV_DATA:   slv_rdata = regs.in_byte;
            SLV_STATUS: slv_rdata = status;
            SLV_CTRL:   slv_rdata = {{(BYTE_W-1){1'b0}}, regs.ie};
            default:    slv_rdata = regs.out_byte;
        endcase
    end
endmodule

// File: rtl/hs_mbx_core.sv
module hs_mbx_core
    import hs_mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  host_evt_t         hevt,
    input  slv_evt_t          sevt,
    output mbx_regs_t         regs,
    output logic [BYTE_W-1:0] status
);
    mbx_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (hevt.in_wr) begin
            r_d.in_byte = hevt.wdata;
            r_d.cd      = hevt.cd;
        end
        if (sevt.out_wr) r_d.out_byte = sevt.wdata;
        if (sevt.sts_wr) r_d.usr      = sevt.wdata & USR_MASK;
        if (sevt.ctl_wr) r_d.ie       = sevt.wdata[0];
        // clear first, then set, so a colliding set prevails
        if (sevt.in_rd) r_d.ibf = 1'b0;
        if (hevt.in_wr) r_d.ibf = 1'b1;
        if (hevt.out_rd || (sevt.sts_wr && !sevt.wdata[OBF_POS])) r_d.obf = 1'b0;
        if (sevt.out_wr) r_d.obf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        regs            = r_q;
        status          = r_q.usr & USR_MASK;
        status[CD_POS]  = r_q.cd;
        status[IBF_POS] = r_q.ibf;
        status[OBF_POS] = r_q.obf;
    end
endmodule

// File: rtl/hs_mailbox.sv
module hs_mailbox
    import hs_mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_cs,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic        host_sel,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic        slv_we,
    input  logic        slv_re,
    input  logic [1:0]  slv_addr,
    input  logic [7:0]  slv_wdata,
    output logic [7:0]  slv_rdata,
    output logic        slv_irq
);
    host_evt_t         hevt;
    slv_evt_t          sevt;
    mbx_regs_t         regs;
    logic [BYTE_W-1:0] sts;

    hs_mbx_host_port u_host (
        .host_cs    (host_cs),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .status     (sts),
        .out_byte   (regs.out_byte),
        .evt        (hevt),
        .host_rdata (host_rdata)
    );

    hs_mbx_slave_port u_slave (
        .slv_we    (slv_we),
        .slv_re    (slv_re),
        .slv_addr  (slv_addr),
        .slv_wdata (slv_wdata),
        .regs      (regs),
        .status    (sts),
        .evt       (sevt),
        .slv_rdata (slv_rdata)
    );

    hs_mbx_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .hevt   (hevt),
        .sevt   (sevt),
        .regs   (regs),
        .status (sts)
    );

    assign slv_irq = regs.ibf & regs.ie;
endmodule

// File: rtl/hs_mailbox_chk.sv
module hs_mailbox_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_cs,
    input logic       host_wr,
    input logic       host_rd,
    input logic       host_sel,
    input logic       slv_we,
    input logic       slv_re,
    input logic [1:0] slv_addr,
    input logic       wd0,
    input logic       slv_irq,
    input logic [7:0] sts
);
    logic h_wr, h_out_rd, s_in_rd, s_out_wr, s_sts_wr;
    assign h_wr     = host_cs & host_wr;
    assign h_out_rd = host_cs & host_rd & ~host_sel;
    assign s_in_rd  = slv_re & (slv_addr == 2'd0);
    assign s_out_wr = slv_we & (slv_addr == 2'd0);
    assign s_sts_wr = slv_we & (slv_addr == 2'd1);

    assert_ibf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        h_wr |=> sts[1]);
    assert_cd_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        h_wr |=> sts[3] == $past(host_sel));
    assert_ibf_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_in_rd && !h_wr) |=> !sts[1]);
    assert_obf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_out_wr |=> sts[0]);
    assert_obf_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_sts_wr && wd0 && !h_out_rd) |=> sts[0] == $past(sts[0]));
    assert_obf_wclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_sts_wr && !wd0) |=> !sts[0]);
    assert_ibf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_wr && !s_in_rd) |=> $stable(sts[1]));

    always_comb begin
        if (rst_n) assert_irq_gate_R9: assert (!slv_irq || sts[1]);
    end
endmodule

bind hs_mailbox hs_mailbox_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_cs  (host_cs),
    .host_wr  (host_wr),
    .host_rd  (host_rd),
    .host_sel (host_sel),
    .slv_we   (slv_we),
    .slv_re   (slv_re),
    .slv_addr (slv_addr),
    .wd0      (slv_wdata[0]),
    .slv_irq  (slv_irq),
    .sts      (sts)
);

// File: tb/hs_mailbox_bench.sv
`timescale 1ns/1ps
module hs_mailbox_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs = 0, host_wr = 0, host_rd = 0, host_sel = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic       slv_we = 0, slv_re = 0;
    logic [1:0] slv_addr = 0;
    logic [7:0] slv_wdata = 0, slv_rdata;
    logic       slv_irq;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;

    // reference state
    logic [7:0] m_in, m_out, m_usr;
    logic       m_cd, m_ibf, m_obf, m_ie;

    always #2.5 clk = ~clk;

    hs_mailbox u_hs_mailbox (
        .clk(clk), .rst_n(rst_n),
        .host_cs(host_cs), .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .slv_we(slv_we), .slv_re(slv_re), .slv_addr(slv_addr),
        .slv_wdata(slv_wdata), .slv_rdata(slv_rdata), .slv_irq(slv_irq)
    );

    function automatic logic [7:0] exp_status();
        return {m_usr[7:4], m_cd, m_usr[2], m_ibf, m_obf};
    endfunction

    function automatic logic [7:0] exp_slave(input logic [1:0] a);
        case (a)
            2'd0:    return m_in;
            2'd1:    return exp_status();
            2'd2:    return {7'd0, m_ie};
            default: return m_out;
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_in = 0; m_out = 0; m_usr = 0; m_cd = 0; m_ibf = 0; m_obf = 0; m_ie = 0;
    endtask

    task automatic model_step();
        logic hw, hor, sir, sow, ssw;
        hw  = host_cs & host_wr;
        hor = host_cs & host_rd & ~host_sel;
        sir = slv_re & (slv_addr == 2'd0);
        sow = slv_we & (slv_addr == 2'd0);
        ssw = slv_we & (slv_addr == 2'd1);
        if (hw) begin m_in = host_wdata; m_cd = host_sel; end
        if (sow) m_out = slv_wdata;
        if (ssw) m_usr = slv_wdata & 8'hF4;
        if (slv_we && slv_addr == 2'd2) m_ie = slv_wdata[0];
        if (sir) m_ibf = 0;
        if (hw)  m_ibf = 1;
        if (hor || (ssw && !slv_wdata[0])) m_obf = 0;
        if (sow) m_obf = 1;
    endtask

    // one cycle: drive on falling edge, compare reads, advance on rising edge
    task automatic step(input string tag,
                        input logic hcs, input logic hwr, input logic hrd, input logic hsel,
                        input logic [7:0] hwd,
                        input logic swe, input logic sre, input logic [1:0] sa,
                        input logic [7:0] swd);
        @(negedge clk);
        host_cs = hcs; host_wr = hwr; host_rd = hrd; host_sel = hsel; host_wdata = hwd;
        slv_we = swe; slv_re = sre; slv_addr = sa; slv_wdata = swd;
        #1;
        if (hcs && hrd) check(tag, "host_rdata", host_rdata, hsel ? exp_status() : m_out);
        if (sre)        check(tag, "slv_rdata", slv_rdata, exp_slave(sa));
        check(tag, "slv_irq", {7'd0, slv_irq}, {7'd0, m_ibf & m_ie});
        @(posedge clk);
        model_step();
    endtask

    task automatic idle();
        step("idle", 0, 0, 0, 0, 8'h00, 0, 0, 2'd0, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state seen from both sides
        step("R1", 1, 0, 1, 1, 8'h00, 0, 1, 2'd1, 8'h00);
        step("R1", 1, 0, 1, 0, 8'h00, 0, 1, 2'd0, 8'h00);
        step("R1", 0, 0, 0, 0, 8'h00, 0, 1, 2'd2, 8'h00);

        // R2 R3: host command write, then status via host
        step("R2", 1, 1, 0, 1, 8'hA5, 0, 0, 2'd0, 8'h00);
        step("R3", 1, 0, 1, 1, 8'h00, 0, 1, 2'd1, 8'h00);
        // R4: slave takes the byte, flag drops next cycle
        step("R4", 0, 0, 0, 0, 8'h00, 0, 1, 2'd0, 8'h00);
        step("R4", 1, 0, 1, 1, 8'h00, 0, 1, 2'd1, 8'h00);
        // R3: data write clears marker
        step("R3", 1, 1, 0, 0, 8'h5A, 0, 0, 2'd0, 8'h00);
        step("R3", 1, 0, 1, 1, 8'h00, 0, 1, 2'd0, 8'h00);
        // R7: host writes leave user bits alone
        step("R7", 1, 0, 1, 1, 8'h00, 0, 1, 2'd1, 8'h00);

        // R5: outbound path
        step("R5", 0, 0, 0, 0, 8'h00, 1, 0, 2'd0, 8'h3C);
        step("R5", 1, 0, 1, 1, 8'h00, 0, 1, 2'd3, 8'h00);
        step("R5", 1, 0, 1, 1, 8'h00, 0, 1, 2'd1, 8'h00);
        step("R5", 1, 0, 1, 0, 8'h00, 0, 0, 2'd0, 8'h00);
        step("R5", 1, 0, 1, 1, 8'h00, 0, 1, 2'd1, 8'h00);

        // R6 R7: status writes from the slave
        step("R6", 0, 0, 0, 0, 8'h00, 1, 0, 2'd0, 8'h77);
        step("R7", 0, 0, 0, 0, 8'h00, 1, 0, 2'd1, 8'hFF);
        step("R6", 1, 0, 1, 1, 8'h00, 0, 1, 2'd1, 8'h00);
        step("R6", 0, 0, 0, 0, 8'h00, 1, 0, 2'd1, 8'h0A);
        step("R6", 1, 0, 1, 1, 8'h00, 0, 1, 2'd1, 8'h00);
        step("R7", 0, 0, 0, 0, 8'h00, 1, 0, 2'd1, 8'hB5);
        step("R7", 1, 0, 1, 1, 8'h00, 0, 1, 2'd1, 8'h00);

        // R8: collisions
        step("R8", 1, 1, 0, 0, 8'h11, 0, 0, 2'd0, 8'h00);
        step("R8", 1, 1, 0, 1, 8'h22, 0, 1, 2'd0, 8'h00);
        step("R8", 1, 0, 1, 1, 8'h00, 0, 1, 2'd1, 8'h00);
        step("R8", 1, 0, 1, 0, 8'h00, 1, 0, 2'd0, 8'h44);
        step("R8", 1, 0, 1, 1, 8'h00, 0, 1, 2'd3, 8'h00);

        // R9: interrupt gating
        step("R9", 0, 0, 0, 0, 8'h00, 1, 0, 2'd2, 8'h01);
        step("R9", 0, 0, 0, 0, 8'h00, 0, 1, 2'd2, 8'h00);
        step("R9", 0, 0, 0, 0, 8'h00, 0, 1, 2'd0, 8'h00);
        step("R9", 1, 1, 0, 0, 8'h99, 0, 0, 2'd0, 8'h00);
        step("R9", 0, 0, 0, 0, 8'h00, 1, 0, 2'd2, 8'h00);
        step("R9", 0, 0, 0, 0, 8'h00, 1, 0, 2'd2, 8'hFF);
        idle();

        // seeded random traffic
        void'($urandom(32'h1D2C3B4A));
        for (int i = 0; i < 3000; i++) begin
            int hk, sk;
            hk = $urandom_range(0, 3);
            sk = $urandom_range(0, 2);
            step("rand", $urandom_range(0, 1) == 1, hk == 1, hk == 2,
                 $urandom_range(0, 1) == 1, 8'($urandom),
                 sk == 1, sk == 2, 2'($urandom), 8'($urandom));
        end
        // final state readout
        step("R7", 1, 0, 1, 1, 8'h00, 0, 1, 2'd1, 8'h00);
        step("R5", 0, 0, 0, 0, 8'h00, 0, 1, 2'd3, 8'h00);
        finish_run();
    end
endmodule